// File: doc/BRIEF.md
# DDR Read Burst Interruption Engine

This block is a synthesizable device-side model of how a four-bank double-data-rate memory sequences its read and write bursts. It runs on a beat clock at twice the memory command rate, so one data beat moves per cycle and a half memory clock is one cycle. Commands (NOP, READ, WRITE, BURST STOP) are sampled only in the cycles marked by `cmd_slot`, which alternates, so command spacing is always counted in whole memory clocks. A small register file stands in for the storage array.

A read returns its first beat a fixed number of half-clocks after the command. The count follows the programmed CAS latency of 2, 2.5 or 3 clocks. It then delivers a full burst of 2, 4 or 8 beats. A later READ to any bank may cut into a running burst: the older burst keeps its beats on the bus until the newer one's latency runs out, and the newer burst then follows with no idle cycle. A BURST STOP ends read data at its own latency, and it opens a window during which WRITE commands are refused. A WRITE that breaks the spacing rules is dropped, and a sticky error flag is raised.

The read data leaves as a valid-only stream. Its timing is fixed by the latency, so it has no ready and no back-pressure. Write data enters through a valid/ready stream: `wr_ready` is high only while an accepted write burst still needs beats, and the source may hold `wr_valid` low in any cycle to stall it.

Top module: `ddr_burst_seq`

## Requirements
- R1: Once reset is released, `rd_valid`, `dq_oe`, `wr_ready` and `proto_err` are low. `cmd_slot` is high in the first cycle and alternates every cycle after that.
- R2: A READ sampled at edge t drives its first beat in cycle t+L, where L is 4, 5 or 6 for `cfg_cl` 0, 1 or 2/3. It then drives one beat per cycle for the burst length: 2, 4 or 8 beats for `cfg_bl` 0, 1 or 2/3. `rd_data` holds the stored word of `rd_bank`/`rd_col`.
- R3: The beats of a burst step upward through the columns and wrap inside the block of columns aligned to the burst length. For a length of 4, a start at column 10 gives 10, 11, 8, 9.
- R4: A READ that arrives while an earlier read is still outstanding drops the earlier burst's unsent beats once its own latency has elapsed. It then runs its full burst with no idle cycle in between. The earlier beats carry on until that point.
- R5: READ commands are accepted at every command slot, that is, one memory clock apart.
- R6: `dq_oe` is high in the cycle before the first beat of a burst and in every beat cycle. It is low in the cycle after the final beat, when no further read follows.
- R7: A BURST STOP sampled at edge t suppresses every read beat due from cycle t+L onward.
- R8: After a BURST STOP, a WRITE is accepted only once the CAS latency, rounded up to whole clocks, has passed. That is 2 clocks for `cfg_cl`=0 and 3 clocks otherwise. A WRITE that comes earlier is rejected.
- R9: A WRITE is rejected while a read is still open, meaning it has not been stopped and its data is still pending or being driven. Read data and `wr_ready` are never high together.
- R10: A rejected command sets `proto_err`, which stays set until reset. A rejected WRITE leaves `wr_ready` low and the array unchanged.
- R11: An accepted WRITE raises `wr_ready` in the next cycle. It then stores exactly burst-length beats, one per cycle with both `wr_valid` and `wr_ready` high, at the column order of R3. After that `wr_ready` falls.
- R12: Commands presented in cycles where `cmd_slot` is low are ignored.
- R13: A READ or WRITE sampled while a write burst is still taking data is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, two cycles per memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bl | input | 2 | Burst length select: 0=2, 1=4, 2/3=8 |
| cfg_cl | input | 2 | CAS latency select: 0=2, 1=2.5, 2/3=3 clocks |
| cmd_slot | output | 1 | High in the cycles whose command is sampled |
| cmd | input | 2 | 0 NOP, 1 READ, 2 WRITE, 3 BURST STOP |
| cmd_bank | input | 2 | Bank of the command |
| cmd_col | input | 6 | Start column of the command |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Write beat accepted when high with `wr_valid` |
| wr_data | input | 16 | Write beat data |
| rd_valid | output | 1 | Read beat on `rd_data` |
| rd_bank | output | 2 | Bank of the current read beat |
| rd_col | output | 6 | Column of the current read beat |
| rd_data | output | 16 | Read beat data |
| dq_oe | output | 1 | Data and strobe driver enable, preamble included |
| proto_err | output | 1 | Sticky protocol error |

## Verification
Each READ is given the number of the edge that sampled it. A negedge monitor logs every beat with its cycle number, so each beat is checked against cycle t+L+k with L set by the latency code. This covers interrupts at one, two and three clocks, where the expected split between the old and new bursts follows from the spacing. Driver-enable checks sample cycle t+L-1 and cycle t+L+burst length. Rejections are checked in the first cycle after the sampling edge, because `proto_err` and `wr_ready` are registered there, and a rejected write is confirmed by reading the word back later.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_STOP  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_READ = 2'd1,
    EV_STOP = 2'd2
  } ev_e;

  // beats per burst
  function automatic logic [3:0] bl_beats(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd2;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  // command-to-first-beat latency in half clocks
  function automatic logic [2:0] lat_half(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd4;
      2'd1:    return 3'd5;
      default: return 3'd6;
    endcase
  endfunction

  // stop-to-write window: 2*ceil(CL) half clocks, minus one for the load edge
  function automatic logic [2:0] stop_gap(input logic [1:0] code);
    return (code == 2'd0) ? 3'd3 : 3'd5;
  endfunction

  // sequential column with wrap inside a burst-aligned block
  function automatic logic [15:0] wrap_col(input logic [15:0] base,
                                           input logic [3:0]  off,
                                           input logic [3:0]  bl);
    logic [15:0] mask;
    mask = {12'd0, bl - 4'd1};
    return (base & ~mask) | ((base + {12'd0, off}) & mask);
  endfunction

endpackage

// File: rtl/ddrb_launch.sv
// Latency line: each event is placed at stage lat-1 and reaches stage 0
// lat-1 edges later, so the burst engine acts on it lat edges after sampling.
module ddrb_launch
  import ddrb_pkg::*;
#(
  parameter int BANKW = 2,
  parameter int COLW  = 6,
  parameter int DEPTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ev_e              ins_kind,
  input  logic [BANKW-1:0] ins_bank,
  input  logic [COLW-1:0]  ins_col,
  input  logic [2:0]       lat,
  output ev_e              head_kind,
  output logic [BANKW-1:0] head_bank,
  output logic [COLW-1:0]  head_col,
  output logic             next_read,
  output logic             any_read
);

  ev_e              kind_q [DEPTH];
  logic [BANKW-1:0] bank_q [DEPTH];
  logic [COLW-1:0]  col_q  [DEPTH];

  ev_e              up_kind [DEPTH];
  logic [BANKW-1:0] up_bank [DEPTH];
  logic [COLW-1:0]  up_col  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_up
    if (i == DEPTH - 1) begin : g_tail
      assign up_kind[i] = EV_NONE;
      assign up_bank[i] = '0;
      assign up_col[i]  = '0;
    end else begin : g_link
      assign up_kind[i] = kind_q[i+1];
      assign up_bank[i] = bank_q[i+1];
      assign up_col[i]  = col_q[i+1];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) begin
        kind_q[i] <= EV_NONE;
        bank_q[i] <= '0;
        col_q[i]  <= '0;
      end else if (ins_kind != EV_NONE && lat == 3'(i + 1)) begin
        kind_q[i] <= ins_kind;
        bank_q[i] <= ins_bank;
        col_q[i]  <= ins_col;
      end else begin
        kind_q[i] <= up_kind[i];
        bank_q[i] <= up_bank[i];
        col_q[i]  <= up_col[i];
      end
    end
  end

  always_comb begin
    any_read = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (kind_q[i] == EV_READ) any_read = 1'b1;
  end

  assign head_kind = kind_q[0];
  assign head_bank = bank_q[0];
  assign head_col  = col_q[0];
  assign next_read = (kind_q[1] == EV_READ);

endmodule

// File: rtl/ddrb_rdburst.sv
// Burst engine: a read reaching the head restarts the burst (interrupt),
// a stop reaching the head ends it, otherwise the running burst steps on.
module ddrb_rdburst
  import ddrb_pkg::*;
#(
  parameter int BANKW = 2,
  parameter int COLW  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       bl,
  input  ev_e              head_kind,
  input  logic [BANKW-1:0] head_bank,
  input  logic [COLW-1:0]  head_col,
  input  logic             next_read,
  output logic             beat_en,
  output logic [BANKW-1:0] beat_bank,
  output logic [COLW-1:0]  beat_col,
  output logic             oe_q
);

  logic             act_q, act_n;
  logic [3:0]       cnt_q, cnt_n;
  logic [COLW-1:0]  base_q, base_n;
  logic [BANKW-1:0] bank_q, bank_n;

  always_comb begin
    act_n     = act_q;
    cnt_n     = cnt_q;
    base_n    = base_q;
    bank_n    = bank_q;
    beat_en   = 1'b0;
    beat_bank = bank_q;
    beat_col  = base_q;
    if (head_kind == EV_READ) begin
      beat_en   = 1'b1;
      beat_bank = head_bank;
      beat_col  = head_col;
      act_n     = 1'b1;
      cnt_n     = 4'd1;
      base_n    = head_col;
      bank_n    = head_bank;
    end else if (head_kind == EV_STOP) begin
      act_n = 1'b0;
    end else if (act_q && cnt_q < bl) begin
      beat_en  = 1'b1;
      beat_col = COLW'(wrap_col(16'(base_q), cnt_q, bl));
      cnt_n    = cnt_q + 4'd1;
    end else begin
      act_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
      bank_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      base_q <= base_n;
      bank_q <= bank_n;
      oe_q   <= beat_en | next_read;
    end
  end

endmodule

// File: rtl/ddrb_store.sv
module ddrb_store #(
  parameter int BANKW = 2,
  parameter int COLW  = 6,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             we,
  input  logic [BANKW-1:0] wbank,
  input  logic [COLW-1:0]  wcol,
  input  logic [DW-1:0]    wdata,
  input  logic [BANKW-1:0] rbank,
  input  logic [COLW-1:0]  rcol,
  output logic [DW-1:0]    rdata
);

  localparam int WORDS = 1 << (BANKW + COLW);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[{wbank, wcol}] <= wdata;
  end

  assign rdata = mem[{rbank, rcol}];

endmodule

// File: rtl/ddr_burst_seq.sv
module ddr_burst_seq
  import ddrb_pkg::*;
#(
  parameter int DW      = 16,
  parameter int COLW    = 6,
  parameter int BANKS   = 4,
  parameter int MAX_LAT = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cfg_bl,
  input  logic [1:0]               cfg_cl,
  output logic                     cmd_slot,
  input  logic [1:0]               cmd,
  input  logic [$clog2(BANKS)-1:0] cmd_bank,
  input  logic [COLW-1:0]          cmd_col,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [DW-1:0]            wr_data,
  output logic                     rd_valid,
  output logic [$clog2(BANKS)-1:0] rd_bank,
  output logic [COLW-1:0]          rd_col,
  output logic [DW-1:0]            rd_data,
  output logic                     dq_oe,
  output logic                     proto_err
);

  localparam int BANKW = $clog2(BANKS);

  logic [3:0] bl;
  logic [2:0] lat;
  assign bl  = bl_beats(cfg_bl);
  assign lat = lat_half(cfg_cl);

  // command phase: sampling happens on alternate edges
  logic ph_q;
  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ~ph_q;
  end
  assign cmd_slot = ~ph_q;

  cmd_e cmd_c;
  assign cmd_c = cmd_e'(cmd);

  logic             wr_act, rd_open;
  logic [2:0]       stop_cnt;
  logic [3:0]       wr_cnt;
  logic [BANKW-1:0] wr_bank;
  logic [COLW-1:0]  wr_base;

  logic is_rd, is_wr, is_st, rd_ok, wr_ok, st_ok, reject;
  assign is_rd  = cmd_slot && cmd_c == CMD_READ;
  assign is_wr  = cmd_slot && cmd_c == CMD_WRITE;
  assign is_st  = cmd_slot && cmd_c == CMD_STOP;
  assign rd_ok  = is_rd && !wr_act;
  assign wr_ok  = is_wr && !wr_act && !rd_open && stop_cnt == 3'd0;
  assign st_ok  = is_st && !wr_act;
  assign reject = (is_rd && wr_act) || (is_wr && !wr_ok);

  ev_e ins_kind;
  always_comb begin
    if (rd_ok)      ins_kind = EV_READ;
    else if (st_ok) ins_kind = EV_STOP;
    else            ins_kind = EV_NONE;
  end

  ev_e              head_kind;
  logic [BANKW-1:0] head_bank;
  logic [COLW-1:0]  head_col;
  logic             next_read, any_read;

  ddrb_launch #(.BANKW(BANKW), .COLW(COLW), .DEPTH(MAX_LAT)) launch_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_kind  (ins_kind),
    .ins_bank  (cmd_bank),
    .ins_col   (cmd_col),
    .lat       (lat),
    .head_kind (head_kind),
    .head_bank (head_bank),
    .head_col  (head_col),
    .next_read (next_read),
    .any_read  (any_read)
  );

  logic             beat_en;
  logic [BANKW-1:0] beat_bank;
  logic [COLW-1:0]  beat_col;

  ddrb_rdburst #(.BANKW(BANKW), .COLW(COLW)) burst_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bl        (bl),
    .head_kind (head_kind),
    .head_bank (head_bank),
    .head_col  (head_col),
    .next_read (next_read),
    .beat_en   (beat_en),
    .beat_bank (beat_bank),
    .beat_col  (beat_col),
    .oe_q      (dq_oe)
  );

  // write burst capture through the valid/ready stream
  logic            wr_fire;
  logic [COLW-1:0] wr_col;
  assign wr_ready = wr_act;
  assign wr_fire  = wr_valid && wr_act;
  assign wr_col   = COLW'(wrap_col(16'(wr_base), wr_cnt, bl));

  logic [DW-1:0] st_rdata;

  ddrb_store #(.BANKW(BANKW), .COLW(COLW), .DW(DW)) store_i (
    .clk   (clk),
    .we    (wr_fire),
    .wbank (wr_bank),
    .wcol  (wr_col),
    .wdata (wr_data),
    .rbank (beat_bank),
    .rcol  (beat_col),
    .rdata (st_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_act    <= 1'b0;
      wr_cnt    <= '0;
      wr_bank   <= '0;
      wr_base   <= '0;
      rd_open   <= 1'b0;
      stop_cnt  <= '0;
      proto_err <= 1'b0;
      rd_valid  <= 1'b0;
      rd_bank   <= '0;
      rd_col    <= '0;
      rd_data   <= '0;
    end else begin
      if (wr_ok) begin
        wr_act  <= 1'b1;
        wr_cnt  <= '0;
        wr_bank <= cmd_bank;
        wr_base <= cmd_col;
      end else if (wr_fire) begin
        wr_cnt <= wr_cnt + 4'd1;
        if (wr_cnt == bl - 4'd1) wr_act <= 1'b0;
      end

      if (rd_ok)      rd_open <= 1'b1;
      else if (st_ok) rd_open <= 1'b0;
      else            rd_open <= rd_open && (any_read || beat_en);

      if (st_ok)                 stop_cnt <= stop_gap(cfg_cl);
      else if (stop_cnt != 3'd0) stop_cnt <= stop_cnt - 3'd1;

      proto_err <= proto_err | reject;

      rd_valid <= beat_en;
      rd_bank  <= beat_bank;
      rd_col   <= beat_col;
      rd_data  <= st_rdata;
    end
  end

endmodule

// File: rtl/ddr_burst_seq_chk.sv
module ddr_burst_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_slot,
  input logic [1:0] cmd,
  input logic       rd_valid,
  input logic       dq_oe,
  input logic       wr_ready,
  input logic       proto_err,
  input logic [2:0] stop_cnt,
  input logic       rd_open
);

  assert_slot_alternate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_slot |=> !cmd_slot);

  assert_slot_return_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_slot |=> cmd_slot);

  assert_oe_covers_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> dq_oe);

  assert_preamble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(dq_oe));

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_ready));

  assert_early_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_slot && cmd == 2'd2 && stop_cnt != 3'd0 && !wr_ready) |=> (proto_err && !wr_ready));

  assert_open_read_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_slot && cmd == 2'd2 && rd_open && !wr_ready) |=> (proto_err && !wr_ready));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

endmodule

bind ddr_burst_seq ddr_burst_seq_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_slot  (cmd_slot),
  .cmd       (cmd),
  .rd_valid  (rd_valid),
  .dq_oe     (dq_oe),
  .wr_ready  (wr_ready),
  .proto_err (proto_err),
  .stop_cnt  (stop_cnt),
  .rd_open   (rd_open)
);

// File: tb/ddr_burst_seq_tb_top.sv
`timescale 1ns/1ps
module ddr_burst_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_bl = 2'd1;
  logic [1:0]  cfg_cl = 2'd2;
  logic        cmd_slot;
  logic [1:0]  cmd = 2'd0;
  logic [1:0]  cmd_bank = '0;
  logic [5:0]  cmd_col = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_data = '0;
  logic        rd_valid;
  logic [1:0]  rd_bank;
  logic [5:0]  rd_col;
  logic [15:0] rd_data;
  logic        dq_oe;
  logic        proto_err;

  always #5 clk = ~clk;

  ddr_burst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_bl(cfg_bl), .cfg_cl(cfg_cl),
    .cmd_slot(cmd_slot), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_bank(rd_bank), .rd_col(rd_col), .rd_data(rd_data),
    .dq_oe(dq_oe), .proto_err(proto_err)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] ref_mem [4][64];

  int          log_t [64];
  logic [15:0] log_d [64];
  logic [5:0]  log_c [64];
  logic [1:0]  log_b [64];
  int          log_n = 0;

  always @(negedge clk) begin
    if (rd_valid && log_n < 64) begin
      log_t[log_n] = cyc;
      log_d[log_n] = rd_data;
      log_c[log_n] = rd_col;
      log_b[log_n] = rd_bank;
      log_n = log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wrapc(input int base, input int k, input int bl);
    return (base & ~(bl - 1)) | ((base + k) & (bl - 1));
  endfunction

  function automatic logic [15:0] mk(input int b, input int c, input int salt);
    return {4'(salt), 2'(b), 6'(c), 4'h5};
  endfunction

  function automatic int lat_of(input logic [1:0] c);
    return (c == 2'd0) ? 4 : (c == 2'd1) ? 5 : 6;
  endfunction

  function automatic int bl_of(input logic [1:0] c);
    return (c == 2'd0) ? 2 : (c == 2'd1) ? 4 : 8;
  endfunction

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // called at a negedge; returns the number of the sampling edge
  task automatic issue(input logic [1:0] c, input int b, input int col, output int t);
    while (!cmd_slot) @(negedge clk);
    cmd = c; cmd_bank = 2'(b); cmd_col = 6'(col);
    @(posedge clk);
    @(negedge clk);
    cmd = 2'd0;
    t = cyc;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd = 2'd0; wr_valid = 1'b0;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic feed(input int b, input int col, input int salt, input bit gap, input string req);
    int k;
    int bl;
    bit gapped;
    bit rdy;
    bl = bl_of(cfg_bl);
    k = 0;
    gapped = 1'b0;
    while (k < bl) begin
      if (gap && k == 1 && !gapped) begin
        wr_valid = 1'b0;
        gapped = 1'b1;
      end else begin
        wr_valid = 1'b1;
        wr_data = mk(b, wrapc(col, k, bl), salt);
      end
      rdy = wr_ready;
      @(posedge clk);
      if (wr_valid && rdy) begin
        ref_mem[b][wrapc(col, k, bl)] = mk(b, wrapc(col, k, bl), salt);
        k++;
      end
      @(negedge clk);
    end
    wr_valid = 1'b0;
    chk(wr_ready == 1'b0, req, wr_ready, 0);
  endtask

  task automatic write_burst(input int b, input int col, input int salt, input bit gap);
    int t;
    issue(2'd2, b, col, t);
    chk(wr_ready == 1'b1, "R11 ready after write", wr_ready, 1);
    feed(b, col, salt, gap, "R11 ready falls after burst");
  endtask

  task automatic expect_beat(input int i, input int t, input int b, input int c, input string req);
    chk(log_t[i] == t, req, log_t[i], t);
    chk(log_b[i] == 2'(b) && log_c[i] == 6'(c), req, {log_b[i], log_c[i]}, {2'(b), 6'(c)});
    chk(log_d[i] == ref_mem[b][c], req, log_d[i], ref_mem[b][c]);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(rd_valid == 0 && dq_oe == 0, "R1 read outputs idle", {rd_valid, dq_oe}, 0);
    chk(wr_ready == 0 && proto_err == 0, "R1 ready/err low", {wr_ready, proto_err}, 0);
    chk(cmd_slot == 1, "R1 first slot", cmd_slot, 1);
    step(1);
    chk(cmd_slot == 0, "R1 slot alternates", cmd_slot, 0);
    step(1);
    chk(cmd_slot == 1, "R1 slot returns", cmd_slot, 1);
  endtask

  task automatic t_read_basic();
    int t;
    issue(2'd1, 1, 8, t);
    step(5);
    chk(dq_oe == 1 && rd_valid == 0, "R6 preamble", {dq_oe, rd_valid}, 2'b10);
    for (int k = 0; k < 4; k++) begin
      step(1);
      chk(rd_valid == 1 && dq_oe == 1, "R2 beat valid", {rd_valid, dq_oe}, 2'b11);
      chk(rd_data == ref_mem[1][8 + k] && rd_col == 6'(8 + k), "R2 beat data", rd_data, ref_mem[1][8 + k]);
    end
    step(1);
    chk(rd_valid == 0 && dq_oe == 0, "R6 oe falls after burst", {rd_valid, dq_oe}, 0);
  endtask

  task automatic t_wrap();
    int t;
    log_n = 0;
    issue(2'd1, 1, 10, t);
    step(10);
    chk(log_n == 4, "R3 beat count", log_n, 4);
    for (int k = 0; k < 4; k++) expect_beat(k, t + 6 + k, 1, wrapc(10, k, 4), "R3 wrap order");
  endtask

  task automatic t_interrupt(input int s);
    int ta, tb, na;
    log_n = 0;
    issue(2'd1, 1, 8, ta);
    if (s > 1) step(2 * (s - 1));
    issue(2'd1, 2, 4, tb);
    step(14);
    na = (2 * s < 4) ? 2 * s : 4;
    chk(tb == ta + 2 * s, "R5 read spacing", tb, ta + 2 * s);
    chk(log_n == na + 4, "R4 interrupt beat count", log_n, na + 4);
    for (int k = 0; k < na; k++) expect_beat(k, ta + 6 + k, 1, wrapc(8, k, 4), "R4 old burst beats");
    for (int k = 0; k < 4; k++) expect_beat(na + k, tb + 6 + k, 2, wrapc(4, k, 4), "R4 new burst full");
  endtask

  task automatic t_cl25();
    int t;
    cfg_cl = 2'd1;
    log_n = 0;
    issue(2'd1, 1, 9, t);
    step(4);
    chk(dq_oe == 1 && rd_valid == 0, "R6 preamble CL2.5", {dq_oe, rd_valid}, 2'b10);
    step(6);
    chk(log_n == 4, "R2 CL2.5 count", log_n, 4);
    for (int k = 0; k < 4; k++) expect_beat(k, t + 5 + k, 1, wrapc(9, k, 4), "R2 CL2.5 timing");
    cfg_cl = 2'd2;
  endtask

  task automatic t_bl8_bl2();
    int t;
    cfg_bl = 2'd2;
    write_burst(3, 5, 7, 1'b0);
    log_n = 0;
    issue(2'd1, 3, 3, t);
    step(16);
    chk(log_n == 8, "R2 BL8 count", log_n, 8);
    for (int k = 0; k < 8; k++) expect_beat(k, t + 6 + k, 3, wrapc(3, k, 8), "R3 BL8 wrap");
    cfg_bl = 2'd0;
    log_n = 0;
    issue(2'd1, 1, 9, t);
    step(10);
    chk(log_n == 2, "R2 BL2 count", log_n, 2);
    for (int k = 0; k < 2; k++) expect_beat(k, t + 6 + k, 1, wrapc(9, k, 2), "R3 BL2 wrap");
    cfg_bl = 2'd1;
  endtask

  task automatic t_slot_ignore();
    log_n = 0;
    while (cmd_slot) @(negedge clk);
    cmd = 2'd1; cmd_bank = 2'd1; cmd_col = 6'd8;
    @(posedge clk);
    @(negedge clk);
    cmd = 2'd0;
    step(12);
    chk(log_n == 0 && proto_err == 0, "R12 off-slot command ignored", log_n, 0);
  endtask

  task automatic t_stop_write_legal();
    int t, ts, tw;
    log_n = 0;
    issue(2'd1, 1, 8, t);
    issue(2'd3, 0, 0, ts);
    step(4);
    issue(2'd2, 0, 0, tw);
    chk(tw == ts + 6, "R8 spacing", tw, ts + 6);
    chk(wr_ready == 1 && proto_err == 0, "R8 legal write accepted", {wr_ready, proto_err}, 2'b10);
    chk(log_n == 2, "R7 stop cuts burst", log_n, 2);
    for (int k = 0; k < 2; k++) expect_beat(k, t + 6 + k, 1, 8 + k, "R7 beats before stop");
    feed(0, 0, 3, 1'b1, "R11 write with stall");
    step(8);
    chk(log_n == 2, "R7 no beats after stop", log_n, 2);
    log_n = 0;
    issue(2'd1, 0, 0, t);
    step(10);
    for (int k = 0; k < 4; k++) expect_beat(k, t + 6 + k, 0, k, "R11 write read back");
  endtask

  task automatic t_stop_write_early();
    int t, ts, tw;
    issue(2'd1, 1, 8, t);
    issue(2'd3, 0, 0, ts);
    step(2);
    issue(2'd2, 0, 0, tw);
    chk(proto_err == 1 && wr_ready == 0, "R8 early write rejected", {proto_err, wr_ready}, 2'b10);
    step(12);
    log_n = 0;
    issue(2'd1, 0, 0, t);
    step(10);
    expect_beat(0, t + 6, 0, 0, "R10 array unchanged");
    chk(proto_err == 1, "R10 error sticky", proto_err, 1);
  endtask

  task automatic t_write_open_read();
    int t, tw;
    issue(2'd1, 1, 8, t);
    step(2);
    issue(2'd2, 0, 4, tw);
    chk(proto_err == 1 && wr_ready == 0, "R9 write during read rejected", {proto_err, wr_ready}, 2'b10);
    step(10);
  endtask

  task automatic t_cmd_during_write();
    int tw, tr;
    log_n = 0;
    issue(2'd2, 2, 12, tw);
    issue(2'd1, 1, 8, tr);
    chk(proto_err == 1, "R13 read during write rejected", proto_err, 1);
    feed(2, 12, 9, 1'b0, "R13 write burst completes");
    step(8);
    chk(log_n == 0, "R13 rejected read sends nothing", log_n, 0);
  endtask

  initial begin
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < 64; c++) ref_mem[b][c] = 16'h0;
    step(3);
    rst_n = 1'b1;
    t_reset();
    write_burst(1, 8, 1, 1'b1);
    write_burst(2, 4, 2, 1'b0);
    write_burst(0, 0, 1, 1'b0);
    t_read_basic();
    t_wrap();
    t_interrupt(1);
    t_interrupt(2);
    t_interrupt(3);
    t_cl25();
    t_bl8_bl2();
    t_slot_ignore();
    t_stop_write_legal();
    t_stop_write_early();
    do_reset();
    t_write_open_read();
    do_reset();
    t_cmd_during_write();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule